// File: doc/BRIEF.md
# Status-Reporting I2C Target Controller

This block is the target (slave) half of an I2C port, working one byte at a time. It resamples SCL and SDA into the system clock, recognises bus START and STOP conditions, shifts address and data bits in on rising SCL edges, and answers either its own 7-bit address or the general call address. After every bus event of interest it raises an interrupt flag and publishes an 8-bit status code that names the event. For byte-level events it also stretches the clock by pulling SCL low, so the bus master waits until software has handled the event.

Software reads the status code and the received byte, and supplies the next byte to transmit. It sets the acknowledge-enable level for the next byte and clears the flag with a strobe. The same strobe also samples the STOP and START request bits. Those two bits only act when the controller is in its bus-error state: STOP alone returns it silently to idle, and STOP with START also sends a START condition on the bus. Both bus lines are open drain. Each line is modelled as an output enable that pulls it low.

Top module: `i2c_status_target`

## Requirements
- R1: After reset the flag is 0, the status reads F8h and neither scl_oe nor sda_oe is asserted.
- R2: When the address byte carries own_addr with R/W bit 0 and ack_en is 1, the controller pulls SDA low in the ninth clock and sets the flag after that clock. The status is then 60h, or 68h if arb_lost was 1 at address time. SCL stays pulled low until sw_clr.
- R3: The address byte 00h with ack_en at 1 is acknowledged and reports 70h, or 78h if arb_lost is 1.
- R4: Own address with R/W bit 1 is acknowledged and reports A8h, or B0h if arb_lost is 1. On the clearing sw_clr, tx_data is loaded and sent MSB first.
- R5: A received data byte is placed on rx_data and acknowledged only if ack_en is 1. It reports 80h (ACK) or 88h (NACK) after an own-address write, and 90h or 98h after a general call. After a NACK the controller no longer responds until the next START.
- R6: After a transmitted byte: master ACK with ack_en=1 at load reports B8h and continues transmitting. Master ACK with ack_en=0 at load (last byte) reports C8h. Master NACK reports C0h. After C0h or C8h, SDA is left released.
- R7: A non-matching address, or any address while ack_en is 0, gets no ACK and does not set the flag.
- R8: A STOP or repeated START that arrives while addressed, before the first SCL fall of a byte, reports A0h with the flag set and SCL not held. After a repeated START the next byte is taken as an address.
- R9: A START or STOP that arrives while addressed, after at least one SCL fall within a byte or during an acknowledge clock, enters the bus-error state. In that state the status is 00h, the flag is set and both lines are released.
- R10: In the bus-error state, sw_clr without sw_stop changes nothing. sw_clr with sw_stop clears the flag, gives status F8h and returns to idle without driving either line.
- R11: sw_clr with both sw_stop and sw_start in the bus-error state pulls SDA low with SCL released for exactly START_HOLD cycles, then releases SDA and rests in idle.
- R12: Whenever the flag is clear the status reads F8h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Own 7-bit target address |
| ack_en | input | 1 | Acknowledge enable for the next byte |
| arb_lost | input | 1 | Master section lost arbitration in its address phase |
| sw_clr | input | 1 | One-cycle strobe: clear the flag |
| sw_stop | input | 1 | STOP request, sampled with sw_clr |
| sw_start | input | 1 | START request, sampled with sw_clr |
| tx_data | input | 8 | Byte to send, sampled with sw_clr |
| irq_flag | output | 1 | Event flag |
| status_o | output | 8 | Status code |
| rx_data | output | 8 | Last received data byte |

## Verification
Leaving the bus-error state and issuing a START are both triggered by one sw_clr strobe that carries STOP and START together. The recovery and the START request are therefore handled in the same cycle. The bench provokes this with a STOP after a few data bits, then applies the combined clear. It judges the result by counting the cycles in which SDA is pulled while SCL is free, which must equal START_HOLD. After that the flag must read clear with status F8h, and a fresh addressed write must work normally.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK,
      ST_HOLD, ST_NOADDR, ST_BERR, ST_RSTART
   } i2cs_state_e;

   typedef enum logic [1:0] { CTX_OWN_W, CTX_GC, CTX_OWN_R } i2cs_ctx_e;
   typedef enum logic [1:0] { NX_RX, NX_TX, NX_UNADDR } i2cs_next_e;

   localparam logic [7:0] SC_OWN_W     = 8'h60;
   localparam logic [7:0] SC_OWN_W_AL  = 8'h68;
   localparam logic [7:0] SC_GC        = 8'h70;
   localparam logic [7:0] SC_GC_AL     = 8'h78;
   localparam logic [7:0] SC_RX_ACK    = 8'h80;
   localparam logic [7:0] SC_RX_NACK   = 8'h88;
   localparam logic [7:0] SC_GRX_ACK   = 8'h90;
   localparam logic [7:0] SC_GRX_NACK  = 8'h98;
   localparam logic [7:0] SC_COND      = 8'hA0;
   localparam logic [7:0] SC_OWN_R     = 8'hA8;
   localparam logic [7:0] SC_OWN_R_AL  = 8'hB0;
   localparam logic [7:0] SC_TX_ACK    = 8'hB8;
   localparam logic [7:0] SC_TX_NACK   = 8'hC0;
   localparam logic [7:0] SC_TX_LAST   = 8'hC8;
   localparam logic [7:0] SC_IDLE      = 8'hF8;
   localparam logic [7:0] SC_BUSERR    = 8'h00;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2cs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2c_status_target.sv
module i2c_status_target
   import i2cs_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int START_HOLD  = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       scl_oe,
   output logic       sda_oe,
   input  logic [6:0] own_addr,
   input  logic       ack_en,
   input  logic       arb_lost,
   input  logic       sw_clr,
   input  logic       sw_stop,
   input  logic       sw_start,
   input  logic [7:0] tx_data,
   output logic       irq_flag,
   output logic [7:0] status_o,
   output logic [7:0] rx_data
);
   localparam int HOLD_W = $clog2(START_HOLD + 1);

   generate
      if (START_HOLD < 4) begin : g_bad_hold
         $error("i2c_status_target: START_HOLD must be at least 4");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, bus_cond;

   i2cs_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
   i2cs_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   i2cs_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   assign bus_cond = start_det | stop_det;

   i2cs_state_e       state;
   i2cs_ctx_e         ctx;
   i2cs_next_e        nxt;
   logic [7:0]        sh;
   logic [3:0]        cnt;
   logic              first_slot, arb_q, acked, last_q, mack;
   logic [HOLD_W-1:0] hold_cnt;
   logic              hit_own, hit_gc;
   logic [7:0]        addr_code, rx_code, tx_code;

   assign hit_own = ack_en && (sh[7:1] == own_addr);
   assign hit_gc  = ack_en && (sh == 8'h00);

   always_comb begin
      unique case (ctx)
         CTX_GC:    addr_code = arb_q ? SC_GC_AL    : SC_GC;
         CTX_OWN_R: addr_code = arb_q ? SC_OWN_R_AL : SC_OWN_R;
         default:   addr_code = arb_q ? SC_OWN_W_AL : SC_OWN_W;
      endcase
      if (ctx == CTX_GC) rx_code = acked ? SC_GRX_ACK : SC_GRX_NACK;
      else               rx_code = acked ? SC_RX_ACK  : SC_RX_NACK;
      tx_code = !mack ? SC_TX_NACK : (last_q ? SC_TX_LAST : SC_TX_ACK);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;   ctx <= CTX_OWN_W;   nxt <= NX_UNADDR;
         sh <= '0;   cnt <= '0;   first_slot <= 1'b0;
         arb_q <= 1'b0;   acked <= 1'b0;   last_q <= 1'b0;   mack <= 1'b0;
         scl_oe <= 1'b0;   sda_oe <= 1'b0;   irq_flag <= 1'b0;
         status_o <= SC_IDLE;   rx_data <= '0;   hold_cnt <= '0;
      end else begin
         if (sw_clr && irq_flag && state != ST_HOLD && state != ST_BERR) begin
            irq_flag <= 1'b0;
            status_o <= SC_IDLE;
         end
         case (state)
            ST_IDLE, ST_NOADDR: begin
               if (start_det) begin
                  state <= ST_ADDR;
                  cnt   <= '0;
               end else if (stop_det) state <= ST_IDLE;
            end
            ST_ADDR: begin
               if (start_det) cnt <= '0;
               else if (stop_det) state <= ST_IDLE;
               else if (scl_rise) begin
                  sh  <= {sh[6:0], sda_s};
                  cnt <= cnt + 4'd1;
               end else if (scl_fall && cnt == 4'd8) begin
                  if (hit_own || hit_gc) begin
                     sda_oe <= 1'b1;
                     arb_q  <= arb_lost;
                     ctx    <= hit_gc ? CTX_GC : (sh[0] ? CTX_OWN_R : CTX_OWN_W);
                     state  <= ST_AACK;
                  end else state <= ST_NOADDR;
               end
            end
            ST_RX, ST_TX: begin
               if (bus_cond) begin
                  sda_oe   <= 1'b0;
                  irq_flag <= 1'b1;
                  cnt      <= '0;
                  if (first_slot) begin
                     status_o <= SC_COND;
                     state    <= start_det ? ST_ADDR : ST_IDLE;
                  end else begin
                     status_o <= SC_BUSERR;
                     scl_oe   <= 1'b0;
                     state    <= ST_BERR;
                  end
               end else if (scl_rise) begin
                  cnt <= cnt + 4'd1;
                  if (state == ST_RX) sh <= {sh[6:0], sda_s};
               end else if (scl_fall) begin
                  first_slot <= 1'b0;
                  if (state == ST_RX) begin
                     if (cnt == 4'd8) begin
                        rx_data <= sh;
                        sda_oe  <= ack_en;
                        acked   <= ack_en;
                        state   <= ST_RACK;
                     end
                  end else if (cnt == 4'd8) begin
                     sda_oe <= 1'b0;
                     state  <= ST_TACK;
                  end else begin
                     sda_oe <= ~sh[6];
                     sh     <= {sh[6:0], 1'b1};
                  end
               end
            end
            ST_AACK, ST_RACK, ST_TACK: begin
               if (bus_cond) begin
                  sda_oe   <= 1'b0;
                  scl_oe   <= 1'b0;
                  irq_flag <= 1'b1;
                  status_o <= SC_BUSERR;
                  state    <= ST_BERR;
               end else if (scl_rise && state == ST_TACK) begin
                  mack <= ~sda_s;
               end else if (scl_fall) begin
                  sda_oe   <= 1'b0;
                  scl_oe   <= 1'b1;
                  irq_flag <= 1'b1;
                  state    <= ST_HOLD;
                  if (state == ST_AACK) begin
                     status_o <= addr_code;
                     nxt      <= (ctx == CTX_OWN_R) ? NX_TX : NX_RX;
                  end else if (state == ST_RACK) begin
                     status_o <= rx_code;
                     nxt      <= acked ? NX_RX : NX_UNADDR;
                  end else begin
                     status_o <= tx_code;
                     nxt      <= (mack && !last_q) ? NX_TX : NX_UNADDR;
                  end
               end
            end
            ST_HOLD: begin
               if (sw_clr) begin
                  irq_flag   <= 1'b0;
                  status_o   <= SC_IDLE;
                  scl_oe     <= 1'b0;
                  cnt        <= '0;
                  first_slot <= 1'b1;
                  case (nxt)
                     NX_RX: state <= ST_RX;
                     NX_TX: begin
                        sh     <= tx_data;
                        sda_oe <= ~tx_data[7];
                        last_q <= ~ack_en;
                        state  <= ST_TX;
                     end
                     default: state <= ST_NOADDR;
                  endcase
               end
            end
            ST_BERR: begin
               if (sw_clr && sw_stop) begin
                  irq_flag <= 1'b0;
                  status_o <= SC_IDLE;
                  if (sw_start) begin
                     sda_oe   <= 1'b1;
                     hold_cnt <= '0;
                     state    <= ST_RSTART;
                  end else state <= ST_IDLE;
               end
            end
            ST_RSTART: begin
               if (hold_cnt == HOLD_W'(START_HOLD - 1)) begin
                  sda_oe <= 1'b0;
                  state  <= ST_IDLE;
               end else hold_cnt <= hold_cnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R2
   scl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq_flag) && status_o != SC_COND && status_o != SC_BUSERR) |-> scl_oe);

   // R8
   cond_nohold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq_flag) && status_o == SC_COND) |-> !scl_oe);

   // R9
   berr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && status_o == SC_BUSERR) |-> (!scl_oe && !sda_oe));

   // R10
   berr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq_flag) && $past(status_o) == SC_BUSERR && !$past(sw_clr && sw_stop))
         |-> (irq_flag && status_o == SC_BUSERR));

   // R12
   idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_flag |-> status_o == SC_IDLE);

endmodule

// File: tb/i2c_status_target_tb_top.sv
`timescale 1ns/1ps
module i2c_status_target_tb_top;
   localparam int HOLD = 16;
   localparam int Q    = 12;
   localparam logic [6:0] OWN = 7'h3A;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic scl_drv = 1'b1, sda_drv = 1'b1;
   logic scl_oe, sda_oe, scl_line, sda_line;
   logic ack_en = 1'b1, arb_lost = 1'b0;
   logic sw_clr = 1'b0, sw_stop = 1'b0, sw_start = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic irq_flag;
   logic [7:0] status_o, rx_data;

   assign scl_line = scl_drv & ~scl_oe;
   assign sda_line = sda_drv & ~sda_oe;

   i2c_status_target #(.SYNC_STAGES(2), .START_HOLD(HOLD)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .ack_en(ack_en),
      .arb_lost(arb_lost), .sw_clr(sw_clr), .sw_stop(sw_stop),
      .sw_start(sw_start), .tx_data(tx_data), .irq_flag(irq_flag),
      .status_o(status_o), .rx_data(rx_data));

   int n_chk = 0, n_fail = 0;

   task automatic chk(input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clk_bit(input logic v, output logic s);
      sda_drv = v;  tick(Q);
      scl_drv = 1'b1;  tick(1);
      while (!scl_line) tick(1);
      tick(Q);
      s = sda_line;
      scl_drv = 1'b0;  tick(Q);
   endtask

   task automatic bus_start();
      sda_drv = 1'b1; tick(Q); scl_drv = 1'b1; tick(Q);
      sda_drv = 1'b0; tick(Q); scl_drv = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_drv = 1'b0; tick(Q); scl_drv = 1'b1; tick(Q);
      sda_drv = 1'b1; tick(Q);
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
      clk_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic rd_byte(input logic mack, output logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         b[i] = s;
      end
      clk_bit(~mack, s);
   endtask

   task automatic sw_ack(input logic stp, input logic sta, input logic [7:0] d);
      sw_clr = 1'b1; sw_stop = stp; sw_start = sta; tx_data = d;
      tick(1);
      sw_clr = 1'b0; sw_stop = 1'b0; sw_start = 1'b0;
      tick(2);
   endtask

   task automatic t_reset();
      chk("R1 flag", irq_flag, 0);
      chk("R1 status", status_o, 8'hF8);
      chk("R1 scl_oe", scl_oe, 0);
      chk("R1 sda_oe", sda_oe, 0);
   endtask

   task automatic t_own_write();
      logic a;
      bus_start();
      wr_byte({OWN, 1'b0}, a);
      chk("R2 ack", a, 1);
      chk("R2 flag", irq_flag, 1);
      chk("R2 status", status_o, 8'h60);
      tick(30);
      chk("R2 scl held", scl_oe, 1);
      sw_ack(0, 0, 8'h00);
      chk("R12 status after clear", status_o, 8'hF8);
      chk("R2 scl released", scl_oe, 0);
      wr_byte(8'hA5, a);
      chk("R5 ack", a, 1);
      chk("R5 status 80", status_o, 8'h80);
      chk("R5 rx_data", rx_data, 8'hA5);
      sw_ack(0, 0, 8'h00);
      ack_en = 1'b0;
      wr_byte(8'h3C, a);
      chk("R5 nack", a, 0);
      chk("R5 status 88", status_o, 8'h88);
      chk("R5 rx_data nack", rx_data, 8'h3C);
      ack_en = 1'b1;
      sw_ack(0, 0, 8'h00);
      wr_byte(8'h11, a);
      chk("R5 unaddressed ack", a, 0);
      chk("R5 unaddressed flag", irq_flag, 0);
      bus_stop();
      chk("R5 stop while unaddressed flag", irq_flag, 0);
   endtask

   task automatic t_arb_write();
      logic a;
      arb_lost = 1'b1;
      bus_start();
      wr_byte({OWN, 1'b0}, a);
      arb_lost = 1'b0;
      chk("R2 arb status", status_o, 8'h68);
      sw_ack(0, 0, 8'h00);
      bus_stop();
      chk("R8 stop flag", irq_flag, 1);
      chk("R8 stop status", status_o, 8'hA0);
      chk("R8 stop scl free", scl_oe, 0);
      sw_ack(0, 0, 8'h00);
      chk("R12 after A0 clear", status_o, 8'hF8);
   endtask

   task automatic t_gc();
      logic a;
      bus_start();
      wr_byte(8'h00, a);
      chk("R3 gc ack", a, 1);
      chk("R3 gc status", status_o, 8'h70);
      sw_ack(0, 0, 8'h00);
      wr_byte(8'h5E, a);
      chk("R5 gc data status", status_o, 8'h90);
      chk("R5 gc rx_data", rx_data, 8'h5E);
      sw_ack(0, 0, 8'h00);
      ack_en = 1'b0;
      wr_byte(8'h77, a);
      chk("R5 gc nack", a, 0);
      chk("R5 gc nack status", status_o, 8'h98);
      ack_en = 1'b1;
      sw_ack(0, 0, 8'h00);
      bus_stop();
      arb_lost = 1'b1;
      bus_start();
      wr_byte(8'h00, a);
      arb_lost = 1'b0;
      chk("R3 gc arb status", status_o, 8'h78);
      sw_ack(0, 0, 8'h00);
      bus_stop();
      sw_ack(0, 0, 8'h00);
   endtask

   task automatic t_read();
      logic a;
      logic [7:0] b;
      bus_start();
      wr_byte({OWN, 1'b1}, a);
      chk("R4 read ack", a, 1);
      chk("R4 read status", status_o, 8'hA8);
      sw_ack(0, 0, 8'hC3);
      rd_byte(1'b1, b);
      chk("R4 tx byte", b, 8'hC3);
      chk("R6 status B8", status_o, 8'hB8);
      ack_en = 1'b0;
      sw_ack(0, 0, 8'h5A);
      rd_byte(1'b1, b);
      chk("R4 tx last byte", b, 8'h5A);
      chk("R6 status C8", status_o, 8'hC8);
      ack_en = 1'b1;
      sw_ack(0, 0, 8'h00);
      rd_byte(1'b1, b);
      chk("R6 released after C8", b, 8'hFF);
      chk("R6 no flag after C8", irq_flag, 0);
      bus_stop();
      arb_lost = 1'b1;
      bus_start();
      wr_byte({OWN, 1'b1}, a);
      arb_lost = 1'b0;
      chk("R4 read arb status", status_o, 8'hB0);
      sw_ack(0, 0, 8'h81);
      rd_byte(1'b0, b);
      chk("R4 tx byte 81", b, 8'h81);
      chk("R6 status C0", status_o, 8'hC0);
      sw_ack(0, 0, 8'h00);
      rd_byte(1'b1, b);
      chk("R6 released after C0", b, 8'hFF);
      bus_stop();
      chk("R6 idle flag", irq_flag, 0);
   endtask

   task automatic t_nomatch();
      logic a;
      bus_start();
      wr_byte(8'h42, a);
      chk("R7 wrong address ack", a, 0);
      chk("R7 wrong address flag", irq_flag, 0);
      bus_stop();
      ack_en = 1'b0;
      bus_start();
      wr_byte({OWN, 1'b0}, a);
      chk("R7 ack_en low ack", a, 0);
      chk("R7 ack_en low flag", irq_flag, 0);
      bus_stop();
      ack_en = 1'b1;
   endtask

   task automatic t_repstart();
      logic a;
      logic [7:0] b;
      bus_start();
      wr_byte({OWN, 1'b0}, a);
      sw_ack(0, 0, 8'h00);
      bus_start();
      chk("R8 rep start flag", irq_flag, 1);
      chk("R8 rep start status", status_o, 8'hA0);
      chk("R8 rep start scl free", scl_oe, 0);
      sw_ack(0, 0, 8'h00);
      wr_byte({OWN, 1'b1}, a);
      chk("R8 address after rep start", status_o, 8'hA8);
      sw_ack(0, 0, 8'hFF);
      rd_byte(1'b0, b);
      sw_ack(0, 0, 8'h00);
      bus_stop();
   endtask

   task automatic t_buserr();
      logic a, s;
      int pulled;
      bus_start();
      wr_byte({OWN, 1'b0}, a);
      sw_ack(0, 0, 8'h00);
      clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
      bus_stop();
      chk("R9 error flag", irq_flag, 1);
      chk("R9 error status", status_o, 8'h00);
      chk("R9 scl released", scl_oe, 0);
      chk("R9 sda released", sda_oe, 0);
      sw_ack(0, 0, 8'h00);
      chk("R10 clear without stop flag", irq_flag, 1);
      chk("R10 clear without stop status", status_o, 8'h00);
      sw_ack(1, 0, 8'h00);
      chk("R10 recovered flag", irq_flag, 0);
      chk("R10 recovered status", status_o, 8'hF8);
      chk("R10 no drive", {scl_oe, sda_oe}, 0);
      bus_start();
      wr_byte({OWN, 1'b0}, a);
      chk("R10 normal after recovery", status_o, 8'h60);
      sw_ack(0, 0, 8'h00);
      clk_bit(1'b0, s); clk_bit(1'b1, s);
      bus_stop();
      chk("R9 second error", status_o, 8'h00);
      sw_clr = 1'b1; sw_stop = 1'b1; sw_start = 1'b1;
      tick(1);
      sw_clr = 1'b0; sw_stop = 1'b0; sw_start = 1'b0;
      pulled = 0;
      for (int i = 0; i < HOLD + 40; i++) begin
         if (sda_oe && !scl_oe && !sda_line && scl_line) pulled++;
         tick(1);
      end
      chk("R11 start hold cycles", pulled, HOLD);
      chk("R11 sda released", sda_oe, 0);
      chk("R11 flag", irq_flag, 0);
      chk("R11 status", status_o, 8'hF8);
      bus_start();
      wr_byte({OWN, 1'b0}, a);
      chk("R11 idle after start", status_o, 8'h60);
      sw_ack(0, 0, 8'h00);
      bus_stop();
      sw_ack(0, 0, 8'h00);
   endtask

   task automatic finish_run();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      tick(4);
      rst_n = 1'b1;
      tick(4);
      t_reset();
      t_own_write();
      t_arb_write();
      t_gc();
      t_read();
      t_nomatch();
      t_repstart();
      t_buserr();
      finish_run();
   end
endmodule